// File: doc/BRIEF.md
# Cache Snoop Invalidation Controller

This block keeps the tag state of a small direct-mapped cache coherent with external memory while another bus master drives the memory bus. When the system releases the processor's address bus (address hold, bus hold or backoff) and pulses the external snoop strobe, the block latches the snoop address and looks it up in its tag, valid and dirty flops. A hit invalidates the line. In write-back mode a hit on a dirty line first raises a write request carrying the line address, and it invalidates the line only after the memory side acknowledges the write.

Whether a strobe is accepted at all depends on the power state. System-management mode always allows snooping. A suspend entered by a halt allows it only when the snoop-on-halt option input is 1. A suspend entered through the suspend pin never allows it. The CPU side installs lines through a fill port. The cache data path and line fetch are handled elsewhere.

Top module: `snoop_inval_ctrl`

## Requirements
- R1: A snoop strobe is accepted only while at least one of `ahold`, `hold` or `boff` is 1; otherwise it leaves `busy`, `done`, `wb_req` and every line unchanged.
- R2: An accepted strobe latches `snoop_addr` at that clock edge, `busy` is 1 after that edge, and the lookup completes at the next edge with a one-cycle `done` pulse, `hit` showing the result and `busy` returning to 0.
- R3: With `wb_mode` = 0, a hit invalidates the line without raising `wb_req`, even if the line is dirty; a later snoop of the same address misses.
- R4: With `wb_mode` = 1, a hit on a dirty line raises `wb_req` at the lookup edge with `wb_addr` = line address (low 4 bits zero), holds both steady until `wb_ack` is sampled 1, and at that edge drops `wb_req`, pulses `done` with `hit` = 1 and invalidates the line.
- R5: With `wb_mode` = 1, a hit on a clean line invalidates it with no `wb_req`.
- R6: A miss (tag differs or line invalid) completes with `hit` = 0 and changes no line.
- R7: While `smm_active` = 1, strobes are accepted regardless of `halt_susp`, `pin_susp` and `snoop_on_halt`.
- R8: Outside system-management mode, while `halt_susp` = 1 and `pin_susp` = 0, a strobe is accepted only if `snoop_on_halt` = 1.
- R9: Outside system-management mode, while `pin_susp` = 1, every strobe is ignored and the addressed line stays valid.
- R10: A strobe accepted while a snoop is in progress is held in one pending slot; `busy` stays 1 through the first completion and the held snoop completes at the following edge.
- R11: `fill_en` = 1 at an edge sets the line at index `fill_addr[7:4]` valid with tag `fill_addr[31:8]` and dirty flag `fill_dirty`.
- R12: After reset all lines are invalid and `busy`, `done`, `hit` and `wb_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ahold | input | 1 | Address hold: address bus released |
| hold | input | 1 | Bus hold: bus released to another master |
| boff | input | 1 | Backoff: bus released immediately |
| eads | input | 1 | Snoop address strobe |
| snoop_addr | input | 32 | Address to be snooped |
| wb_mode | input | 1 | 1 = write-back cache, 0 = write-through |
| smm_active | input | 1 | System-management mode active |
| halt_susp | input | 1 | Suspend entered through a halt |
| pin_susp | input | 1 | Suspend entered through the suspend pin |
| snoop_on_halt | input | 1 | Allow snooping during halt suspend |
| fill_en | input | 1 | Install a line |
| fill_addr | input | 32 | Address of the installed line |
| fill_dirty | input | 1 | Dirty flag of the installed line |
| wb_req | output | 1 | Write-back of a dirty line requested |
| wb_addr | output | 32 | Line address of the write-back |
| wb_ack | input | 1 | Write-back finished |
| busy | output | 1 | Snoop in progress |
| done | output | 1 | One-cycle pulse at snoop completion |
| hit | output | 1 | Result of the completed snoop, valid with `done` |

## Verification
Every output is a register, so after the edge that accepts a strobe `busy` is due at once, `done` and `hit` one edge later, and on a dirty write-back hit `wb_req` and `wb_addr` one edge later with `done` due at the edge that samples `wb_ack`. The bench drives inputs and samples outputs at falling edges and counts rising edges between strobe and sample to match those latencies exactly. Invalidation and the absence of effect of ignored strobes are observed by a following snoop of the same address and its `hit` result. The sweeps cover all sixteen lines, all three bus-release inputs and all sixteen combinations of the four power-state inputs.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WB     = 2'd2
  } snoop_state_e;
endpackage

// File: rtl/snoop_gate.sv
module snoop_gate (
  input  logic ahold,
  input  logic hold,
  input  logic boff,
  input  logic eads,
  input  logic smm_active,
  input  logic halt_susp,
  input  logic pin_susp,
  input  logic snoop_on_halt,
  output logic accept
);
  logic released;
  logic permitted;

  assign released = ahold | hold | boff;

  // power-state priority: management mode, then pin suspend, then halt suspend
  always_comb begin
    if (smm_active)      permitted = 1'b1;
    else if (pin_susp)   permitted = 1'b0;
    else if (halt_susp)  permitted = snoop_on_halt;
    else                 permitted = 1'b1;
  end

  assign accept = eads & released & permitted;
endmodule

// File: rtl/snoop_tag_array.sv
module snoop_tag_array #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             inval_en,
  input  logic [IDX_W-1:0] inval_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[g]   <= '0;
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (inval_en && inval_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        tag_q[g]   <= fill_tag;
        valid_q[g] <= 1'b1;
        dirty_q[g] <= fill_dirty;
      end
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  // R3: an invalidated line reads invalid after the edge
  p_inval_clears_r3: assert property (@(posedge clk) disable iff (rst)
    inval_en |=> !valid_q[$past(inval_idx)]);

  // R11: a fill without a competing invalidate leaves the line valid
  p_fill_sets_r11: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inval_en) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFS_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              wb_mode,
  input  logic              wb_ack,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              rd_valid,
  input  logic              rd_dirty,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              inval_en,
  output logic [IDX_W-1:0]  inval_idx,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              busy,
  output logic              done,
  output logic              hit
);
  snoop_state_e      state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_q;
  logic              wb_req_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic              busy_q;
  logic              done_q;
  logic              hit_q;

  logic [TAG_W-1:0]  cur_tag;
  logic              look_hit;
  logic              need_wb;
  logic              finish;

  assign rd_idx   = cur_q[OFS_W +: IDX_W];
  assign cur_tag  = cur_q[ADDR_W-1 -: TAG_W];
  assign look_hit = rd_valid && (rd_tag == cur_tag);
  assign need_wb  = look_hit && rd_dirty && wb_mode;

  always_comb begin
    finish = 1'b0;
    if (state_q == ST_LOOKUP) finish = !need_wb;
    else if (state_q == ST_WB) finish = wb_ack;
  end

  assign inval_en  = finish && ((state_q == ST_WB) || look_hit);
  assign inval_idx = rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      pend_addr_q <= '0;
      pend_q      <= 1'b0;
      wb_req_q    <= 1'b0;
      wb_addr_q   <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      hit_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_q   <= snoop_addr;
            state_q <= ST_LOOKUP;
            busy_q  <= 1'b1;
          end
        end
        ST_LOOKUP: begin
          if (need_wb) begin
            state_q   <= ST_WB;
            wb_req_q  <= 1'b1;
            wb_addr_q <= {cur_tag, rd_idx, {OFS_W{1'b0}}};
          end
        end
        ST_WB: begin
          if (wb_ack) wb_req_q <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase

      if (finish) begin
        done_q <= 1'b1;
        hit_q  <= (state_q == ST_WB) || look_hit;
        if (pend_q) begin
          cur_q   <= pend_addr_q;
          state_q <= ST_LOOKUP;
          busy_q  <= 1'b1;
          pend_q  <= accept;
          if (accept) pend_addr_q <= snoop_addr;
        end else if (accept) begin
          cur_q   <= snoop_addr;
          state_q <= ST_LOOKUP;
          busy_q  <= 1'b1;
        end else begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
      end else if (state_q != ST_IDLE && accept && !pend_q) begin
        pend_q      <= 1'b1;
        pend_addr_q <= snoop_addr;
      end
    end
  end

  assign wb_req  = wb_req_q;
  assign wb_addr = wb_addr_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign hit     = hit_q;

  // R4: request held until acknowledged
  p_wb_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> wb_req);

  // R4: line address steady while the request waits
  p_wb_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_ack) |=> $stable(wb_addr));

  // R3: write-through lookup never opens a write-back
  p_wt_no_wb_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && !wb_mode) |=> !wb_req);

  // R10: a held snoop keeps the controller busy
  p_pend_busy_r10: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> busy_q);
endmodule

// File: rtl/snoop_inval_ctrl.sv
module snoop_inval_ctrl #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFS_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ahold,
  input  logic              hold,
  input  logic              boff,
  input  logic              eads,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              wb_mode,
  input  logic              smm_active,
  input  logic              halt_susp,
  input  logic              pin_susp,
  input  logic              snoop_on_halt,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack,
  output logic              busy,
  output logic              done,
  output logic              hit
);
  logic             accept;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_valid;
  logic             rd_dirty;
  logic             inval_en;
  logic [IDX_W-1:0] inval_idx;

  snoop_gate i_gate (
    .ahold         (ahold),
    .hold          (hold),
    .boff          (boff),
    .eads          (eads),
    .smm_active    (smm_active),
    .halt_susp     (halt_susp),
    .pin_susp      (pin_susp),
    .snoop_on_halt (snoop_on_halt),
    .accept        (accept)
  );

  snoop_tag_array #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) i_tags (
    .clk        (clk),
    .rst        (rst),
    .fill_en    (fill_en),
    .fill_idx   (fill_addr[OFS_W +: IDX_W]),
    .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
    .fill_dirty (fill_dirty),
    .inval_en   (inval_en),
    .inval_idx  (inval_idx),
    .rd_idx     (rd_idx),
    .rd_tag     (rd_tag),
    .rd_valid   (rd_valid),
    .rd_dirty   (rd_dirty)
  );

  snoop_ctrl #(
    .ADDR_W     (ADDR_W),
    .LINES      (LINES),
    .LINE_BYTES (LINE_BYTES)
  ) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .snoop_addr (snoop_addr),
    .wb_mode    (wb_mode),
    .wb_ack     (wb_ack),
    .rd_tag     (rd_tag),
    .rd_valid   (rd_valid),
    .rd_dirty   (rd_dirty),
    .rd_idx     (rd_idx),
    .inval_en   (inval_en),
    .inval_idx  (inval_idx),
    .wb_req     (wb_req),
    .wb_addr    (wb_addr),
    .busy       (busy),
    .done       (done),
    .hit        (hit)
  );

  // R1: a strobe without a bus-release input starts nothing
  p_no_release_r1: assert property (@(posedge clk) disable iff (rst)
    (eads && !ahold && !hold && !boff && !busy) |=> !busy);

  // R9: pin suspend outside management mode blocks the strobe
  p_pin_susp_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (eads && pin_susp && !smm_active && !busy) |=> !busy);

  // R2: completion only follows a busy cycle
  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
endmodule

// File: tb/test_snoop_inval_ctrl.sv
`timescale 1ns/1ps
module test_snoop_inval_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ahold = 0, hold = 0, boff = 0, eads = 0;
  logic [31:0] snoop_addr = '0;
  logic        wb_mode = 0, smm_active = 0, halt_susp = 0, pin_susp = 0, snoop_on_halt = 0;
  logic        fill_en = 0, fill_dirty = 0, wb_ack = 0;
  logic [31:0] fill_addr = '0;
  logic        wb_req, busy, done, hit;
  logic [31:0] wb_addr;
  int          nchk = 0;
  int          nerr = 0;

  always #5 clk = ~clk;

  snoop_inval_ctrl i_snoop_inval_ctrl (
    .clk(clk), .rst(rst), .ahold(ahold), .hold(hold), .boff(boff), .eads(eads),
    .snoop_addr(snoop_addr), .wb_mode(wb_mode), .smm_active(smm_active),
    .halt_susp(halt_susp), .pin_susp(pin_susp), .snoop_on_halt(snoop_on_halt),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
    .busy(busy), .done(done), .hit(hit)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[23:0], idx[3:0], 4'h0};
  endfunction

  task automatic fill(input logic [31:0] a, input logic d);
    fill_en = 1; fill_addr = a; fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  // starts and ends just after a falling edge
  task automatic snoop(input logic [31:0] a, input int rel, input logic acc,
                       input logic exp_hit, input logic exp_wb, input string req);
    ahold = (rel == 0); hold = (rel == 1); boff = (rel == 2);
    eads = 1; snoop_addr = a;
    @(negedge clk);
    eads = 0;
    chk(req, "busy after strobe", busy, acc);
    if (!acc) begin
      repeat (2) @(negedge clk);
      chk(req, "ignored busy", busy, 0);
      chk(req, "ignored done", done, 0);
      chk(req, "ignored wb_req", wb_req, 0);
    end else begin
      @(negedge clk);
      if (exp_wb) begin
        chk(req, "wb_req", wb_req, 1);
        chk(req, "wb_addr", wb_addr, {a[31:4], 4'h0});
        chk(req, "done before ack", done, 0);
        repeat (2) @(negedge clk);
        chk(req, "wb_req held", wb_req, 1);
        chk(req, "wb_addr held", wb_addr, {a[31:4], 4'h0});
        wb_ack = 1;
        @(negedge clk);
        wb_ack = 0;
        chk(req, "done after ack", done, 1);
        chk(req, "hit after ack", hit, 1);
        chk(req, "wb_req dropped", wb_req, 0);
        chk(req, "busy after ack", busy, 0);
      end else begin
        chk(req, "done", done, 1);
        chk(req, "hit", hit, exp_hit);
        chk(req, "no wb_req", wb_req, 0);
        chk(req, "busy cleared", busy, 0);
      end
    end
    ahold = 0; hold = 0; boff = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    chk("R12", "busy", busy, 0);
    chk("R12", "done", done, 0);
    chk("R12", "hit", hit, 0);
    chk("R12", "wb_req", wb_req, 0);
    for (int i = 0; i < 16; i++) snoop(mk(0, i), i % 3, 1, 0, 0, "R12");

    // R4 R5 R11: write-back sweep, odd lines dirty
    wb_mode = 1;
    for (int i = 0; i < 16; i++) fill(mk(24'hA500 + i * 37, i), i[0]);
    for (int i = 0; i < 16; i++)
      snoop(mk(24'hA500 + i * 37, i), i % 3, 1, 1, i[0], i[0] ? "R4" : "R5");
    for (int i = 0; i < 16; i++) snoop(mk(24'hA500 + i * 37, i), (i + 1) % 3, 1, 0, 0, "R4");

    // R3: write-through sweep, all lines dirty
    wb_mode = 0;
    for (int i = 0; i < 16; i++) fill(mk(24'h3C00 + i, i), 1);
    for (int i = 0; i < 16; i++) snoop(mk(24'h3C00 + i, i), i % 3, 1, 1, 0, "R3");
    for (int i = 0; i < 16; i++) snoop(mk(24'h3C00 + i, i), i % 3, 1, 0, 0, "R3");

    // R6: miss leaves the line intact
    fill(mk(24'h1234, 5), 0);
    snoop(mk(24'h1235, 5), 1, 1, 0, 0, "R6");
    snoop(mk(24'h1234, 6), 1, 1, 0, 0, "R6");
    snoop(mk(24'h1234, 5), 1, 1, 1, 0, "R6");

    // R1: no bus release, strobe ignored, line kept
    fill(mk(24'h0777, 3), 0);
    snoop(mk(24'h0777, 3), 3, 0, 0, 0, "R1");
    snoop(mk(24'h0777, 3), 2, 1, 1, 0, "R1");

    // R7 R8 R9: all power-state combinations
    for (int c = 0; c < 16; c++) begin
      logic s, h, p, f, perm;
      string rq;
      s = c[3]; h = c[2]; p = c[1]; f = c[0];
      perm = s | (!p & (!h | f));
      rq = s ? "R7" : (p ? "R9" : (h ? "R8" : "R2"));
      fill(mk(24'h4400 + c, 7), 0);
      smm_active = s; halt_susp = h; pin_susp = p; snoop_on_halt = f;
      snoop(mk(24'h4400 + c, 7), c % 3, perm, 1, 0, rq);
      smm_active = 0; halt_susp = 0; pin_susp = 0; snoop_on_halt = 0;
      snoop(mk(24'h4400 + c, 7), 0, 1, !perm, 0, rq);
    end

    // R10: strobe during a write-back wait is held
    wb_mode = 1;
    fill(mk(24'hBEEF, 2), 1);
    fill(mk(24'hCAFE, 9), 0);
    hold = 1;
    eads = 1; snoop_addr = mk(24'hBEEF, 2);
    @(negedge clk);
    eads = 0;
    chk("R10", "busy first", busy, 1);
    @(negedge clk);
    chk("R10", "wb_req first", wb_req, 1);
    eads = 1; snoop_addr = mk(24'hCAFE, 9);
    @(negedge clk);
    eads = 0;
    chk("R10", "busy while held", busy, 1);
    chk("R10", "done while held", done, 0);
    wb_ack = 1;
    @(negedge clk);
    wb_ack = 0;
    chk("R10", "first done", done, 1);
    chk("R10", "first hit", hit, 1);
    chk("R10", "busy kept", busy, 1);
    chk("R10", "wb_req dropped", wb_req, 0);
    @(negedge clk);
    chk("R10", "second done", done, 1);
    chk("R10", "second hit", hit, 1);
    chk("R10", "busy cleared", busy, 0);
    chk("R10", "no second wb", wb_req, 0);
    hold = 0;
    @(negedge clk);
    snoop(mk(24'hCAFE, 9), 0, 1, 0, 0, "R10");
    snoop(mk(24'hBEEF, 2), 0, 1, 0, 0, "R10");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule